// File: doc/BRIEF.md
# Streaming S-Record Image Loader

This block accepts an ASCII character stream, one character per valid beat, as a serial receiver would deliver it. It parses Motorola S-record text lines and turns every data byte into a single byte-lane write on a word-wide memory port. The memory, the character receiver and whatever later runs the loaded image all sit outside the block.

Each record is decoded field by field. The record type comes first, then the length, the address and the data, and the last byte is the checksum. The block keeps an 8-bit running sum over the record and compares its ones complement with the final byte. A fixed base address is subtracted from the record address, and the resulting byte offset is checked against the memory size. The offset selects a word and a byte lane. Lane placement depends on the configured word width and on the byte order.

At the end of each record the block raises a sticky error with a code if the record was faulty. A clean end-of-load record produces a one-cycle completion pulse.

Top module: `srec_loader`

## Requirements
- R1: After reset, wr_en_o, done_o and err_o are low, err_code_o is 0, and char_ready_o is high.
- R2: Space, CR and LF characters are ignored between records. Any other character there that is not 'S' opens a faulty record that runs to the next CR or LF and is reported with format code 1.
- R3: The character after 'S' must be a digit 0 to 9, or the record gets format code 1. Hex fields accept the digits 0-9 and the letters A-F in either case. Any other character inside a hex field gives format code 1.
- R4: Two hex characters after the type give the length: the number of bytes that follow, counting address, data and checksum. Types 1, 2 and 3 carry an address of 2, 3 or 4 bytes, most significant byte first.
- R5: A data record carries length minus (type+2) data bytes, at consecutive byte addresses starting from the record address. Each data byte whose address is in range produces exactly one write, registered on the clock edge that accepts its second hex character. The write has a one-hot byte enable, and the byte is copied onto every lane of wr_data_o.
- R6: Records of type 0 and 4 to 9 consume length minus 1 bytes into the checksum and never write.
- R7: The checksum byte must equal the bitwise inverse of the 8-bit wrapping sum of the length, address and data (or skipped) bytes. A mismatch gives code 3 unless cs_bypass_i is high.
- R8: The byte offset is the byte address minus BASE_ADDR. An address below BASE_ADDR, or an offset of MEM_BYTES or more, suppresses the write of that byte and gives code 2 for the record.
- R9: wr_addr_o is the byte offset divided by WORD_W/8. With little-endian order, offset bits select lane 0 (bits 7:0) upward. With big-endian order, lane k maps to lane WORD_W/8-1-k. For a 16-bit word this means offset bit 0 = 0 goes to bits 15:8.
- R10: A CR or LF ends a record. A faulty record sets err_o and err_code_o on the clock edge that accepts the ending character, with priority format (1) over address (2) over checksum (3). Both stay fixed until reset, so only the first faulty record is reported. The in-range bytes of a faulty record are still written.
- R11: A record of type 7, 8 or 9 that ends with no fault pulses done_o for one cycle, on the edge that accepts its ending character. The parser then waits idle for the next record.
- R12: The following are all format code 1: a length of 0, a data record whose length is below type+2, a CR or LF before the checksum, and any character other than CR or LF after the checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_valid_i | input | 1 | Character beat valid |
| char_i | input | 8 | ASCII character |
| char_ready_o | output | 1 | Character accepted (always high) |
| cs_bypass_i | input | 1 | Disable checksum fault reporting |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | IDX_W | Word index |
| wr_be_o | output | WORD_W/8 | One-hot byte enable |
| wr_data_o | output | WORD_W | Data byte copied onto all lanes |
| done_o | output | 1 | End-of-load pulse |
| err_o | output | 1 | Sticky record fault |
| err_code_o | output | 2 | First fault code: 1 format, 2 address, 3 checksum |

## Verification
The bench builds two instances that share one character stream. One is 32 bits wide and little-endian; the other is 16 bits wide and big-endian. Both use BASE_ADDR 0x1000 and MEM_BYTES 256, so both lane mappings are compared against the same byte image. The small memory puts both range edges within reach of short records: an address just below the base, and a record that runs past the last byte. The 8-bit variant is only elaborated.

// File: rtl/srec_pkg.sv
package srec_pkg;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_FMT  = 2'd1,
    ERR_ADDR = 2'd2,
    ERR_CSUM = 2'd3
  } err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TYPE,
    ST_LEN_H,
    ST_LEN_L,
    ST_BODY_H,
    ST_BODY_L,
    ST_EOL,
    ST_SKIP
  } pstate_e;

endpackage

// File: rtl/srec_char.sv
module srec_char (
  input  logic [7:0] char_i,
  output logic       is_hex_o,
  output logic       is_dig_o,
  output logic [3:0] nib_o,
  output logic       is_eol_o,
  output logic       is_space_o,
  output logic       is_s_o
);

  logic is_up, is_lo;

  assign is_dig_o   = (char_i >= 8'h30) && (char_i <= 8'h39);
  assign is_up      = (char_i >= 8'h41) && (char_i <= 8'h46);
  assign is_lo      = (char_i >= 8'h61) && (char_i <= 8'h66);
  assign is_hex_o   = is_dig_o | is_up | is_lo;
  // letters: low nibble is 1..6, value is that plus 9
  assign nib_o      = is_dig_o ? char_i[3:0] : char_i[3:0] + 4'd9;
  assign is_eol_o   = (char_i == 8'h0d) || (char_i == 8'h0a);
  assign is_space_o = (char_i == 8'h20);
  assign is_s_o     = (char_i == 8'h53);

endmodule

// File: rtl/srec_parser.sv
module srec_parser
  import srec_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic        is_hex_i,
  input  logic        is_dig_i,
  input  logic [3:0]  nib_i,
  input  logic        is_eol_i,
  input  logic        is_space_i,
  input  logic        is_s_i,
  output logic        byte_we_o,
  output logic [7:0]  byte_val_o,
  output logic [31:0] byte_addr_o,
  output logic        rec_start_o,
  output logic        rec_end_o,
  output logic        fmt_o,
  output logic        cs_bad_o,
  output logic        term_o
);

  pstate_e     st_q, st_d;
  logic [3:0]  typ_q, typ_d;
  logic [7:0]  len_q, len_d;
  logic [7:0]  bidx_q, bidx_d;
  logic [3:0]  hi_q, hi_d;
  logic [31:0] addr_q, addr_d;
  logic [7:0]  sum_q, sum_d;
  logic        fmt_q, fmt_d;
  logic        csb_q, csb_d;

  logic       is_data;
  logic [7:0] alen;
  logic [7:0] cur_byte;

  assign is_data  = (typ_q == 4'd1) || (typ_q == 4'd2) || (typ_q == 4'd3);
  assign alen     = 8'(typ_q) + 8'd1;
  assign cur_byte = {hi_q, nib_i};

  always_comb begin
    st_d        = st_q;
    typ_d       = typ_q;
    len_d       = len_q;
    bidx_d      = bidx_q;
    hi_d        = hi_q;
    addr_d      = addr_q;
    sum_d       = sum_q;
    fmt_d       = fmt_q;
    csb_d       = csb_q;
    byte_we_o   = 1'b0;
    rec_start_o = 1'b0;
    rec_end_o   = 1'b0;
    if (valid_i) begin
      unique case (st_q)
        ST_IDLE: begin
          if (is_s_i) begin
            rec_start_o = 1'b1;
            fmt_d       = 1'b0;
            csb_d       = 1'b0;
            st_d        = ST_TYPE;
          end else if (!(is_space_i || is_eol_i)) begin
            rec_start_o = 1'b1;
            fmt_d       = 1'b1;
            csb_d       = 1'b0;
            st_d        = ST_SKIP;
          end
        end
        ST_TYPE: begin
          if (is_eol_i) begin
            fmt_d = 1'b1; rec_end_o = 1'b1; st_d = ST_IDLE;
          end else if (is_dig_i) begin
            typ_d = nib_i;
            st_d  = ST_LEN_H;
          end else begin
            fmt_d = 1'b1; st_d = ST_SKIP;
          end
        end
        ST_LEN_H, ST_BODY_H: begin
          if (is_eol_i) begin
            fmt_d = 1'b1; rec_end_o = 1'b1; st_d = ST_IDLE;
          end else if (is_hex_i) begin
            hi_d = nib_i;
            st_d = (st_q == ST_LEN_H) ? ST_LEN_L : ST_BODY_L;
          end else begin
            fmt_d = 1'b1; st_d = ST_SKIP;
          end
        end
        ST_LEN_L: begin
          if (is_eol_i) begin
            fmt_d = 1'b1; rec_end_o = 1'b1; st_d = ST_IDLE;
          end else if (is_hex_i) begin
            len_d  = cur_byte;
            sum_d  = cur_byte;
            bidx_d = 8'd0;
            addr_d = 32'd0;
            if ((cur_byte == 8'd0) || (is_data && (cur_byte < alen + 8'd1))) begin
              fmt_d = 1'b1; st_d = ST_SKIP;
            end else begin
              st_d = ST_BODY_H;
            end
          end else begin
            fmt_d = 1'b1; st_d = ST_SKIP;
          end
        end
        ST_BODY_L: begin
          if (is_eol_i) begin
            fmt_d = 1'b1; rec_end_o = 1'b1; st_d = ST_IDLE;
          end else if (is_hex_i) begin
            if (bidx_q == len_q - 8'd1) begin
              csb_d = (~sum_q != cur_byte);
              st_d  = ST_EOL;
            end else begin
              sum_d  = sum_q + cur_byte;
              bidx_d = bidx_q + 8'd1;
              st_d   = ST_BODY_H;
              if (is_data && (bidx_q < alen)) begin
                addr_d = {addr_q[23:0], cur_byte};
              end else if (is_data) begin
                byte_we_o = 1'b1;
                addr_d    = addr_q + 32'd1;
              end
            end
          end else begin
            fmt_d = 1'b1; st_d = ST_SKIP;
          end
        end
        ST_EOL: begin
          if (is_eol_i) begin
            rec_end_o = 1'b1; st_d = ST_IDLE;
          end else begin
            fmt_d = 1'b1; st_d = ST_SKIP;
          end
        end
        ST_SKIP: begin
          if (is_eol_i) begin
            rec_end_o = 1'b1; st_d = ST_IDLE;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign byte_val_o  = cur_byte;
  assign byte_addr_o = addr_q;
  assign fmt_o       = fmt_d;
  assign cs_bad_o    = csb_q;
  assign term_o      = (typ_q >= 4'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      typ_q  <= 4'd0;
      len_q  <= 8'd0;
      bidx_q <= 8'd0;
      hi_q   <= 4'd0;
      addr_q <= 32'd0;
      sum_q  <= 8'd0;
      fmt_q  <= 1'b0;
      csb_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      typ_q  <= typ_d;
      len_q  <= len_d;
      bidx_q <= bidx_d;
      hi_q   <= hi_d;
      addr_q <= addr_d;
      sum_q  <= sum_d;
      fmt_q  <= fmt_d;
      csb_q  <= csb_d;
    end
  end

endmodule

// File: rtl/srec_lane.sv
module srec_lane #(
  parameter int          WORD_W     = 32,
  parameter int          MEM_BYTES  = 4096,
  parameter logic [31:0] BASE_ADDR  = 32'h0,
  parameter bit          BIG_ENDIAN = 1'b0,
  localparam int BYTES = WORD_W / 8,
  localparam int WORDS = MEM_BYTES / BYTES,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int LB    = $clog2(BYTES)
) (
  input  logic [31:0]       byte_addr_i,
  input  logic [7:0]        byte_i,
  output logic              in_range_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [BYTES-1:0]  be_o,
  output logic [WORD_W-1:0] data_o
);

  logic [31:0] off;

  assign off        = byte_addr_i - BASE_ADDR;
  assign in_range_o = (byte_addr_i >= BASE_ADDR) && (off < 32'(MEM_BYTES));
  assign data_o     = {BYTES{byte_i}};

  generate
    if (BYTES == 1) begin : g_narrow
      assign be_o  = 1'b1;
      assign idx_o = IDX_W'(off);
    end else begin : g_wide
      logic [LB-1:0] lane;
      if (BIG_ENDIAN) begin : g_big
        assign lane = LB'(BYTES - 1) - off[LB-1:0];
      end else begin : g_little
        assign lane = off[LB-1:0];
      end
      assign be_o  = BYTES'(1) << lane;
      assign idx_o = IDX_W'(off >> LB);
    end
  endgenerate

endmodule

// File: rtl/srec_loader.sv
module srec_loader
  import srec_pkg::*;
#(
  parameter int          WORD_W     = 32,
  parameter int          MEM_BYTES  = 4096,
  parameter logic [31:0] BASE_ADDR  = 32'h0,
  parameter bit          BIG_ENDIAN = 1'b0,
  localparam int BYTES = WORD_W / 8,
  localparam int WORDS = MEM_BYTES / BYTES,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_valid_i,
  input  logic [7:0]        char_i,
  output logic              char_ready_o,
  input  logic              cs_bypass_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_addr_o,
  output logic [BYTES-1:0]  wr_be_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_code_o
);

  logic        is_hex, is_dig, is_eol, is_space, is_s;
  logic [3:0]  nib;
  logic        byte_we, rec_start, rec_end, fmt, cs_bad, term;
  logic [7:0]  byte_val;
  logic [31:0] byte_addr;
  logic              in_range;
  logic [IDX_W-1:0]  l_idx;
  logic [BYTES-1:0]  l_be;
  logic [WORD_W-1:0] l_data;

  logic              wr_en_q, done_q, err_q, addr_err_q;
  logic [IDX_W-1:0]  wr_addr_q;
  logic [BYTES-1:0]  wr_be_q;
  logic [WORD_W-1:0] wr_data_q;
  err_e              code_q, code;

  assign char_ready_o = 1'b1;

  srec_char u_char (
    .char_i     (char_i),
    .is_hex_o   (is_hex),
    .is_dig_o   (is_dig),
    .nib_o      (nib),
    .is_eol_o   (is_eol),
    .is_space_o (is_space),
    .is_s_o     (is_s)
  );

  srec_parser u_parser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (char_valid_i),
    .is_hex_i    (is_hex),
    .is_dig_i    (is_dig),
    .nib_i       (nib),
    .is_eol_i    (is_eol),
    .is_space_i  (is_space),
    .is_s_i      (is_s),
    .byte_we_o   (byte_we),
    .byte_val_o  (byte_val),
    .byte_addr_o (byte_addr),
    .rec_start_o (rec_start),
    .rec_end_o   (rec_end),
    .fmt_o       (fmt),
    .cs_bad_o    (cs_bad),
    .term_o      (term)
  );

  srec_lane #(
    .WORD_W     (WORD_W),
    .MEM_BYTES  (MEM_BYTES),
    .BASE_ADDR  (BASE_ADDR),
    .BIG_ENDIAN (BIG_ENDIAN)
  ) u_lane (
    .byte_addr_i (byte_addr),
    .byte_i      (byte_val),
    .in_range_o  (in_range),
    .idx_o       (l_idx),
    .be_o        (l_be),
    .data_o      (l_data)
  );

  // record verdict: format over address over checksum
  always_comb begin
    if (fmt)                         code = ERR_FMT;
    else if (addr_err_q)             code = ERR_ADDR;
    else if (cs_bad && !cs_bypass_i) code = ERR_CSUM;
    else                             code = ERR_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_q    <= 1'b0;
      wr_addr_q  <= '0;
      wr_be_q    <= '0;
      wr_data_q  <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      code_q     <= ERR_NONE;
      addr_err_q <= 1'b0;
    end else begin
      wr_en_q <= byte_we && in_range;
      if (byte_we) begin
        wr_addr_q <= l_idx;
        wr_be_q   <= l_be;
        wr_data_q <= l_data;
      end
      if (rec_start)                 addr_err_q <= 1'b0;
      else if (byte_we && !in_range) addr_err_q <= 1'b1;
      done_q <= rec_end && term && (code == ERR_NONE);
      if (rec_end && (code != ERR_NONE) && !err_q) begin
        err_q  <= 1'b1;
        code_q <= code;
      end
    end
  end

  assign wr_en_o    = wr_en_q;
  assign wr_addr_o  = wr_addr_q;
  assign wr_be_o    = wr_be_q;
  assign wr_data_o  = wr_data_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign err_code_o = code_q;

endmodule

// File: rtl/srec_loader_chk.sv
module srec_loader_chk #(
  parameter int WORD_W    = 32,
  parameter int MEM_BYTES = 4096,
  localparam int BYTES = WORD_W / 8,
  localparam int WORDS = MEM_BYTES / BYTES,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              char_valid_i,
  input logic              wr_en_o,
  input logic [IDX_W-1:0]  wr_addr_o,
  input logic [BYTES-1:0]  wr_be_o,
  input logic [WORD_W-1:0] wr_data_o,
  input logic              done_o,
  input logic              err_o,
  input logic [1:0]        err_code_o
);

  p_be_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $countones(wr_be_o) == 1);

  p_lane_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> wr_data_o == {BYTES{wr_data_o[7:0]}});

  p_write_after_char_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(char_valid_i));

  p_idx_in_mem_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> 32'(wr_addr_o) < 32'(WORDS));

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o && $stable(err_code_o));

  p_err_code_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> err_code_o != 2'd0);

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_no_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && wr_en_o));

endmodule

bind srec_loader srec_loader_chk #(
  .WORD_W    (WORD_W),
  .MEM_BYTES (MEM_BYTES)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .char_valid_i (char_valid_i),
  .wr_en_o      (wr_en_o),
  .wr_addr_o    (wr_addr_o),
  .wr_be_o      (wr_be_o),
  .wr_data_o    (wr_data_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .err_code_o   (err_code_o)
);

// File: tb/tb_srec_loader.sv
`timescale 1ns/1ps
module tb_srec_loader;

  localparam logic [31:0] BASE = 32'h1000;
  localparam int          MEMB = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [7:0] ch = 8'h00;
  logic bypass = 1'b0;

  always #10 clk = ~clk;

  logic        rdy32, w32_en, d32, e32;
  logic [5:0]  w32_addr;
  logic [3:0]  w32_be;
  logic [31:0] w32_data;
  logic [1:0]  c32;
  logic        rdy16, w16_en, d16, e16;
  logic [6:0]  w16_addr;
  logic [1:0]  w16_be;
  logic [15:0] w16_data;
  logic [1:0]  c16;

  srec_loader #(.WORD_W(32), .MEM_BYTES(MEMB), .BASE_ADDR(BASE), .BIG_ENDIAN(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .char_valid_i(valid), .char_i(ch), .char_ready_o(rdy32),
    .cs_bypass_i(bypass), .wr_en_o(w32_en), .wr_addr_o(w32_addr), .wr_be_o(w32_be),
    .wr_data_o(w32_data), .done_o(d32), .err_o(e32), .err_code_o(c32));

  srec_loader #(.WORD_W(16), .MEM_BYTES(MEMB), .BASE_ADDR(BASE), .BIG_ENDIAN(1'b1)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .char_valid_i(valid), .char_i(ch), .char_ready_o(rdy16),
    .cs_bypass_i(bypass), .wr_en_o(w16_en), .wr_addr_o(w16_addr), .wr_be_o(w16_be),
    .wr_data_o(w16_data), .done_o(d16), .err_o(e16), .err_code_o(c16));

  logic [7:0]  exp_img [0:MEMB-1];
  logic [31:0] act32   [0:MEMB/4-1];
  logic [15:0] act16   [0:MEMB/2-1];
  logic [7:0]  rec_data [0:15];
  int n_chk = 0, n_err = 0;
  int n_wr32 = 0, n_wr16 = 0, n_done32 = 0, n_done16 = 0;
  int exp_wr = 0, exp_done = 0;
  bit exp_err = 1'b0;
  int exp_code = 0;
  bit finished = 1'b0;

  initial begin
    for (int i = 0; i < MEMB; i++) exp_img[i] = 8'h00;
    for (int i = 0; i < MEMB/4; i++) act32[i] = 32'h0;
    for (int i = 0; i < MEMB/2; i++) act16[i] = 16'h0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (w32_en) begin
        for (int b = 0; b < 4; b++) if (w32_be[b]) act32[w32_addr][8*b +: 8] = w32_data[8*b +: 8];
        n_wr32++;
      end
      if (w16_en) begin
        for (int b = 0; b < 2; b++) if (w16_be[b]) act16[w16_addr][8*b +: 8] = w16_data[8*b +: 8];
        n_wr16++;
      end
      if (d32) n_done32++;
      if (d16) n_done16++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] hexch(input logic [3:0] v, input bit lc);
    if (v < 4'd10) return 8'h30 + 8'(v);
    return (lc ? 8'h61 : 8'h41) + 8'(v) - 8'd10;
  endfunction

  task automatic send_char(input logic [7:0] c);
    if ($urandom_range(0, 3) == 0) begin
      valid = 1'b0;
      @(negedge clk);
    end
    valid = 1'b1;
    ch    = c;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_char(hexch(b[7:4], 1'($urandom_range(0, 1))));
    send_char(hexch(b[3:0], 1'($urandom_range(0, 1))));
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_char(s[i]);
  endtask

  task automatic note_code(input int code);
    if (code != 0 && !exp_err) begin
      exp_err  = 1'b1;
      exp_code = code;
    end
  endtask

  task automatic send_rec(input int typ, input logic [31:0] addr, input int n, input bit cs_fault);
    int alen;
    logic [7:0] len, sum;
    bit afault;
    int code;
    afault = 1'b0;
    alen = (typ >= 1 && typ <= 3) ? typ + 1 : 0;
    len  = 8'(alen + n + 1);
    sum  = len;
    for (int i = 0; i < $urandom_range(0, 2); i++) send_char(8'h20);
    send_char(8'h53);
    send_char(8'h30 + 8'(typ));
    send_byte(len);
    for (int i = alen - 1; i >= 0; i--) begin
      send_byte(addr[8*i +: 8]);
      sum = sum + addr[8*i +: 8];
    end
    for (int i = 0; i < n; i++) begin
      send_byte(rec_data[i]);
      sum = sum + rec_data[i];
    end
    send_byte(~sum ^ {7'd0, cs_fault});
    case ($urandom_range(0, 2))
      0: begin send_char(8'h0d); send_char(8'h0a); end
      1: send_char(8'h0a);
      default: send_char(8'h0d);
    endcase
    if (alen > 0) begin
      for (int i = 0; i < n; i++) begin
        logic [31:0] a;
        a = addr + 32'(i);
        if (a >= BASE && a - BASE < MEMB) begin
          exp_img[a - BASE] = rec_data[i];
          exp_wr++;
        end else afault = 1'b1;
      end
    end
    code = afault ? 2 : ((cs_fault && !bypass) ? 3 : 0);
    note_code(code);
    if (code == 0 && typ >= 7) exp_done++;
  endtask

  task automatic send_bad(input string s);
    send_str(s);
    note_code(1);
  endtask

  task automatic check_status(input string req);
    @(negedge clk);
    @(negedge clk);
    chk(e32 == exp_err && c32 == 2'(exp_code), req, "status w32", {e32, c32}, {exp_err, 2'(exp_code)});
    chk(e16 == exp_err && c16 == 2'(exp_code), req, "status w16", {e16, c16}, {exp_err, 2'(exp_code)});
    chk(n_done32 == exp_done && n_done16 == exp_done, req, "done count",
        64'(n_done32 * 1000 + n_done16), 64'(exp_done * 1001));
    chk(n_wr32 == exp_wr && n_wr16 == exp_wr, req, "write count",
        64'(n_wr32 * 1000 + n_wr16), 64'(exp_wr * 1001));
  endtask

  task automatic check_images(input string req);
    int bad32, bad16;
    logic [31:0] g32, x32;
    logic [15:0] g16, x16;
    bad32 = 0; bad16 = 0;
    g32 = 0; x32 = 0; g16 = 0; x16 = 0;
    for (int i = 0; i < MEMB/4; i++) begin
      logic [31:0] e;
      e = {exp_img[4*i+3], exp_img[4*i+2], exp_img[4*i+1], exp_img[4*i]};
      if (act32[i] != e) begin
        if (bad32 == 0) begin g32 = act32[i]; x32 = e; end
        bad32++;
      end
    end
    for (int i = 0; i < MEMB/2; i++) begin
      logic [15:0] e;
      e = {exp_img[2*i], exp_img[2*i+1]};
      if (act16[i] != e) begin
        if (bad16 == 0) begin g16 = act16[i]; x16 = e; end
        bad16++;
      end
    end
    chk(bad32 == 0, req, "32-bit little-endian image word", 64'(g32), 64'(x32));
    chk(bad16 == 0, req, "16-bit big-endian image word", 64'(g16), 64'(x16));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    exp_err  = 1'b0;
    exp_code = 0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R1 reset state
    chk(!w32_en && !w16_en && !d32 && !d16, "R1", "strobes after reset", {w32_en, w16_en, d32, d16}, 0);
    chk(!e32 && !e16 && c32 == 0 && c16 == 0, "R1", "error after reset", {e32, e16, c32, c16}, 0);
    chk(rdy32 && rdy16, "R1", "ready", {rdy32, rdy16}, 2'b11);

    // R9 directed lane placement
    rec_data[0] = 8'h11; rec_data[1] = 8'h22; rec_data[2] = 8'h33; rec_data[3] = 8'h44;
    send_rec(1, 32'h1000, 4, 1'b0);
    check_status("R5");
    chk(act32[0] == 32'h44332211, "R9", "little-endian word 0", 64'(act32[0]), 64'h44332211);
    chk(act16[0] == 16'h1122 && act16[1] == 16'h3344, "R9", "big-endian words 0/1",
        {act16[0], act16[1]}, 32'h11223344);

    // R2 R3 R4 R5 R6 random mixed-case records with spaces and header/count records
    for (int r = 0; r < 40; r++) begin
      int off, n, t;
      off = $urandom_range(0, 250);
      n   = $urandom_range(1, 8);
      if (off + n > MEMB) n = MEMB - off;
      for (int i = 0; i < 16; i++) rec_data[i] = 8'($urandom);
      t = $urandom_range(1, 3);
      send_rec(t, BASE + 32'(off), n, 1'b0);
      if ($urandom_range(0, 3) == 0) send_rec(($urandom_range(0, 1) == 0) ? 0 : 5, 32'h0, $urandom_range(1, 6), 1'b0);
    end
    check_status("R4");
    check_images("R5");

    // R6 header record with payload writes nothing
    for (int i = 0; i < 16; i++) rec_data[i] = 8'hA5;
    send_rec(0, 32'h0, 10, 1'b0);
    check_status("R6");

    // R11 termination records
    send_rec(9, 32'h1000, 0, 1'b0);
    check_status("R11");
    send_rec(8, 32'h1000, 0, 1'b0);
    send_rec(7, 32'h1000, 0, 1'b0);
    check_status("R11");

    // R7 bypass hides a checksum fault
    bypass = 1'b1;
    rec_data[0] = 8'h5A; rec_data[1] = 8'hC3;
    send_rec(1, 32'h1010, 2, 1'b1);
    check_status("R7");
    bypass = 1'b0;

    // R7 R10 checksum fault, bytes still written
    rec_data[0] = 8'h01; rec_data[1] = 8'h02; rec_data[2] = 8'h03;
    send_rec(2, 32'h1020, 3, 1'b1);
    check_status("R7");
    check_images("R10");
    // R10 sticky: later format fault keeps checksum code
    send_bad("Sx\r\n");
    check_status("R10");
    // R11 faulty termination record gives no done
    send_rec(9, 32'h1000, 0, 1'b1);
    check_status("R11");

    // R8 address below base
    do_reset();
    rec_data[0] = 8'hEE; rec_data[1] = 8'hEF;
    send_rec(1, 32'h0FFE, 2, 1'b0);
    check_status("R8");
    // R8 record running past the end
    do_reset();
    rec_data[0] = 8'hA1; rec_data[1] = 8'hA2; rec_data[2] = 8'hA3; rec_data[3] = 8'hA4;
    send_rec(3, 32'h10FE, 4, 1'b0);
    check_status("R8");
    check_images("R8");
    // R10 priority: address over checksum
    do_reset();
    rec_data[0] = 8'h77;
    send_rec(1, 32'h0FF0, 1, 1'b1);
    check_status("R10");

    // R2 stray lead character
    do_reset(); send_bad("  Q12\r\n"); check_status("R2");
    // R3 non-digit type, non-hex in field
    do_reset(); send_bad("SA03\r\n"); check_status("R3");
    do_reset(); send_bad("S1051G00\r\n"); check_status("R3");
    // R12 early end, zero length, short data record, trailing garbage
    do_reset(); send_bad("S1051000\r\n"); check_status("R12");
    do_reset(); send_bad("S100\r\n"); check_status("R12");
    do_reset(); send_bad("S1021000\r\n"); check_status("R12");
    do_reset(); send_bad("S0030000FCZ\r\n"); check_status("R12");
    // R11 clean end after reset still completes
    do_reset(); send_rec(9, 32'h1000, 0, 1'b0); check_status("R11");
    check_images("R9");

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule